// File: doc/BRIEF.md
# Charge Current Pulse Modulator

This block drives the single charge-enable line of a battery charger from a requested charge phase. In the full-rate phase it works as a hysteretic bang-bang regulator. Two comparator flags come from the sense-resistor voltage: one says the sense voltage is below 0.04 of the supply, the other says it is above 0.05 of the supply. The enable line is switched on and off so that the current stays between those two levels.

In the reduced-rate phases the block produces fixed on/off pulse patterns, timed by an internal microsecond tick. The hold-off and top-off phase uses a 260 us enabled window followed by 1820 us disabled, which gives one eighth of the fast rate. The trickle phase uses one 260 us enabled window per period. That period comes from the timer configuration and is chosen so that the average is a C/512 rate.

When the current source is regulated externally, the sense input is grounded and the gated-mode select is raised. The enable line then simply stays on for as long as a charge window is open. A controller above this block selects the phase. The analog comparators and the power stage sit outside it.

Top module: `chgpulse_top`

The control is a four-state machine:
- ST_IDLE: no charging.
- ST_STEADY: full-rate, with no window.
- ST_WIN_ON: the enabled window of a pulse pattern.
- ST_WIN_OFF: the disabled window of a pulse pattern.

The transitions are:
- Any state goes to ST_IDLE when the phase is off.
- Any state goes to ST_STEADY or ST_WIN_ON on a phase change ("restart").
- ST_WIN_ON goes to ST_WIN_OFF when the on window expires ("on_done").
- ST_WIN_OFF goes to ST_WIN_ON when the off window expires ("off_done").
- ST_STEADY holds.

## Requirements
- R1: The phase code is 0 = off, 1 = fast, 2 = reduced (hold-off/top-off), 3 = trickle. The enable is low during reset, and low after every clock edge at which the phase input is 0.
- R2: In phase 1 with the gated select high, the enable is high after every clock edge.
- R3: In phase 1 with the gated select low, the enable is set high by the edge that sees sns_lo_i and cleared by the edge that sees sns_hi_i. With neither flag it keeps its level. With both flags it goes low.
- R4: The hysteresis memory is cleared while the phase is 0, so entering phase 1 with neither flag set leaves the enable low.
- R5: In phase 2 the enable is high for ON_US*CLK_PER_US cycles, then low for OFF_US*CLK_PER_US cycles, repeating. The first high cycle follows the edge that first sees the phase.
- R6: In phase 3 the enable is high for ON_US*CLK_PER_US cycles, then low for (trickle_per_i - ON_US)*CLK_PER_US cycles, repeating. If trickle_per_i <= ON_US, the low part lasts one microsecond.
- R7: Any change of phase to a nonzero code restarts the pattern with its enabled window, from the edge that sees the new code.
- R8: In phases 2 and 3 with the gated select low, the enable follows the R3 hysteresis inside the enabled window and stays low outside it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset |
| phase_i | input | 2 | requested charge phase (R1 encoding) |
| sns_lo_i | input | 1 | sense voltage below the low threshold |
| sns_hi_i | input | 1 | sense voltage above the high threshold |
| gated_i | input | 1 | external regulation: enable held on in open windows |
| trickle_per_i | input | PER_W | trickle period in microseconds |
| en_o | output | 1 | charge enable (registered) |

## Verification
The bench builds the block with CLK_PER_US=2, ON_US=3, OFF_US=21 and PER_W=8. These values keep the 1:7 ratio of the reduced pattern, and every window fits in a few dozen cycles. Several full periods of each pattern are therefore compared cycle by cycle. The bench drives trickle periods of 12 and 2 microseconds, which reach both the normal trickle low time and the clamped one-microsecond case. The short windows also allow phase changes in the middle of an enabled window and hysteresis flags that land inside and outside the window.

// File: rtl/chgpulse_pkg.sv
`timescale 1ns/1ps
package chgpulse_pkg;

    typedef enum logic [1:0] {
        PH_OFF     = 2'd0,
        PH_FAST    = 2'd1,
        PH_REDUCED = 2'd2,
        PH_TRICKLE = 2'd3
    } phase_e;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_WIN_ON  = 2'd1,
        ST_WIN_OFF = 2'd2,
        ST_STEADY  = 2'd3
    } state_e;

endpackage

// File: rtl/chgpulse_tick.sv
`timescale 1ns/1ps
module chgpulse_tick #(
    parameter int DIV = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic tick
);
    localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [DW-1:0] div_q;

    assign tick = (div_q == DW'(DIV - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (clr || tick) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end
endmodule

// File: rtl/chgpulse_window.sv
`timescale 1ns/1ps
module chgpulse_window #(
    parameter int CW = 20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          tick,
    input  logic [CW-1:0] lim,
    output logic          done
);
    logic [CW-1:0] cnt_q;

    assign done = tick && (cnt_q == (lim - 1'b1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/chgpulse_hyst.sv
`timescale 1ns/1ps
module chgpulse_hyst (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic lo,
    input  logic hi,
    output logic level_d
);
    logic level_q;

    always_comb begin
        if (!arm) begin
            level_d = 1'b0;
        end else if (hi) begin
            level_d = 1'b0;
        end else if (lo) begin
            level_d = 1'b1;
        end else begin
            level_d = level_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            level_q <= 1'b0;
        end else begin
            level_q <= level_d;
        end
    end
endmodule

// File: rtl/chgpulse_top.sv
`timescale 1ns/1ps
module chgpulse_top #(
    parameter int CLK_PER_US = 200,
    parameter int ON_US      = 260,
    parameter int OFF_US     = 1820,
    parameter int PER_W      = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       phase_i,
    input  logic             sns_lo_i,
    input  logic             sns_hi_i,
    input  logic             gated_i,
    input  logic [PER_W-1:0] trickle_per_i,
    output logic             en_o
);
    import chgpulse_pkg::*;

    localparam int CW = PER_W;
    localparam logic [CW-1:0] ON_LIM  = CW'(ON_US);
    localparam logic [CW-1:0] OFF_LIM = CW'(OFF_US);

    phase_e        ph_in;
    phase_e        ph_q;
    state_e        state_q;
    state_e        state_d;
    logic          restart;
    logic          tick;
    logic          tick_clr;
    logic          win_clr;
    logic          win_done;
    logic          hyst_d;
    logic          en_q;
    logic          open_d;
    logic [CW-1:0] trickle_off;
    logic [CW-1:0] win_lim;

    assign ph_in       = phase_e'(phase_i);
    assign restart     = (ph_in != ph_q);
    assign trickle_off = (trickle_per_i > ON_LIM) ? (trickle_per_i - ON_LIM) : CW'(1);
    assign win_lim     = (state_q == ST_WIN_ON) ? ON_LIM :
                         ((ph_in == PH_TRICKLE) ? trickle_off : OFF_LIM);
    assign tick_clr    = restart || (ph_in == PH_OFF);
    assign win_clr     = tick_clr || win_done;

    chgpulse_tick #(.DIV(CLK_PER_US)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tick_clr),
        .tick  (tick)
    );

    chgpulse_window #(.CW(CW)) u_win (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (win_clr),
        .tick  (tick),
        .lim   (win_lim),
        .done  (win_done)
    );

    chgpulse_hyst u_hyst (
        .clk     (clk),
        .rst_n   (rst_n),
        .arm     (ph_in != PH_OFF),
        .lo      (sns_lo_i),
        .hi      (sns_hi_i),
        .level_d (hyst_d)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (ph_in == PH_OFF) begin
            state_d = ST_IDLE;
        end else if (restart) begin
            state_d = (ph_in == PH_FAST) ? ST_STEADY : ST_WIN_ON;
        end else begin
            unique case (state_q)
                ST_IDLE:    state_d = (ph_in == PH_FAST) ? ST_STEADY : ST_WIN_ON;
                ST_WIN_ON:  if (win_done) state_d = ST_WIN_OFF;
                ST_WIN_OFF: if (win_done) state_d = ST_WIN_ON;
                ST_STEADY:  state_d = ST_STEADY;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            ph_q    <= PH_OFF;
        end else begin
            state_q <= state_d;
            ph_q    <= ph_in;
        end
    end

    // output decode of the state being entered
    always_comb begin
        unique case (state_d)
            ST_IDLE:    open_d = 1'b0;
            ST_WIN_ON:  open_d = 1'b1;
            ST_WIN_OFF: open_d = 1'b0;
            ST_STEADY:  open_d = 1'b1;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= 1'b0;
        end else begin
            en_q <= open_d && (gated_i || hyst_d);
        end
    end

    assign en_o = en_q;
endmodule

// File: rtl/chgpulse_sva.sv
`timescale 1ns/1ps
module chgpulse_sva #(
    parameter int CLK_PER_US = 200,
    parameter int ON_US      = 260
) (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] phase_i,
    input logic       sns_lo_i,
    input logic       sns_hi_i,
    input logic       gated_i,
    input logic       en_o
);
    localparam int ON_CYC = ON_US * CLK_PER_US;

    logic [1:0] prev_ph;
    int         run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_ph <= 2'd0;
            run_q   <= 0;
        end else begin
            prev_ph <= phase_i;
            if (phase_i != prev_ph || phase_i < 2'd2 || !en_o) begin
                run_q <= 0;
            end else begin
                run_q <= run_q + 1;
            end
        end
    end

    p_off_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_i == 2'd0) |=> !en_o);

    p_gated_fast_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_i == 2'd1 && gated_i) |=> en_o);

    p_hi_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_i != 2'd0 && !gated_i && sns_hi_i) |=> !en_o);

    p_lo_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_i == 2'd1 && !gated_i && sns_lo_i && !sns_hi_i) |=> en_o);

    p_on_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= ON_CYC);

    p_restart_on_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_i != 2'd0 && phase_i != prev_ph && gated_i) |=> en_o);
endmodule

bind chgpulse_top chgpulse_sva #(
    .CLK_PER_US (CLK_PER_US),
    .ON_US      (ON_US)
) u_sva (
    .clk      (clk),
    .rst_n    (rst_n),
    .phase_i  (phase_i),
    .sns_lo_i (sns_lo_i),
    .sns_hi_i (sns_hi_i),
    .gated_i  (gated_i),
    .en_o     (en_o)
);

// File: tb/chgpulse_top_tb.sv
`timescale 1ns/1ps
module chgpulse_top_tb;
    localparam int K     = 2;
    localparam int ON    = 3;
    localparam int OFF   = 21;
    localparam int PW    = 8;
    localparam int ONC   = ON * K;
    localparam int OFFC  = OFF * K;

    typedef struct {
        int    due;
        logic  val;
        string req;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    phase = 2'd0;
    logic          lo = 1'b0;
    logic          hi = 1'b0;
    logic          gated = 1'b0;
    logic [PW-1:0] per = PW'(12);
    logic          en_o;

    int   cyc = 0;
    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;
    exp_t sb_q[$];

    always #2.5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    chgpulse_top #(
        .CLK_PER_US (K),
        .ON_US      (ON),
        .OFF_US     (OFF),
        .PER_W      (PW)
    ) u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .phase_i       (phase),
        .sns_lo_i      (lo),
        .sns_hi_i      (hi),
        .gated_i       (gated),
        .trickle_per_i (per),
        .en_o          (en_o)
    );

    // monitor: compares each expected item in its own cycle
    always @(negedge clk) begin
        if (sb_q.size() > 0 && sb_q[0].due == cyc) begin
            exp_t it;
            it = sb_q.pop_front();
            checks++;
            if (en_o !== it.val) begin
                errors++;
                $display("FAIL %s cycle %0d: en_o=%b expected %b", it.req, cyc, en_o, it.val);
            end
        end
    end

    task automatic apply(input logic [1:0] ph, input logic l, input logic h, input logic g);
        phase = ph;
        lo    = l;
        hi    = h;
        gated = g;
    endtask

    task automatic expect_run(input logic v, input int n, input string req);
        for (int i = 0; i < n; i++) begin
            sb_q.push_back('{due: cyc + 1, val: v, req: req});
            @(posedge clk);
            #1;
        end
    endtask

    initial begin
        #(50000 * 5);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not finish, actual hung expected done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            checks++;
            if (en_o !== 1'b0) begin
                errors++;
                $display("FAIL R1 reset: en_o=%b expected 0", en_o);
            end
        end
        @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: off phase stays low
        apply(2'd0, 1'b1, 1'b0, 1'b1);
        expect_run(1'b0, 5, "R1");

        // R5: reduced pattern, gated
        apply(2'd2, 1'b0, 1'b0, 1'b1);
        expect_run(1'b1, ONC, "R5"); expect_run(1'b0, OFFC, "R5");
        expect_run(1'b1, ONC, "R5"); expect_run(1'b0, OFFC, "R5");
        expect_run(1'b1, ONC, "R5");
        apply(2'd0, 1'b0, 1'b0, 1'b1);
        expect_run(1'b0, 4, "R1");

        // R6: trickle period 12 us
        per = PW'(12);
        apply(2'd3, 1'b0, 1'b0, 1'b1);
        expect_run(1'b1, ONC, "R6"); expect_run(1'b0, (12 - ON) * K, "R6");
        expect_run(1'b1, ONC, "R6"); expect_run(1'b0, (12 - ON) * K, "R6");
        expect_run(1'b1, 2, "R6");
        apply(2'd0, 1'b0, 1'b0, 1'b1);
        expect_run(1'b0, 3, "R1");

        // R6: period not above the window clamps low time to 1 us
        per = PW'(2);
        apply(2'd3, 1'b0, 1'b0, 1'b1);
        expect_run(1'b1, ONC, "R6"); expect_run(1'b0, K, "R6");
        expect_run(1'b1, ONC, "R6"); expect_run(1'b0, K, "R6");
        apply(2'd0, 1'b0, 1'b0, 1'b1);
        expect_run(1'b0, 3, "R1");

        // R2: fast gated
        apply(2'd1, 1'b0, 1'b0, 1'b1);
        expect_run(1'b1, 20, "R2");
        // R7: fast to reduced restarts with enabled window
        apply(2'd2, 1'b0, 1'b0, 1'b1);
        expect_run(1'b1, ONC, "R7"); expect_run(1'b0, 4, "R7");
        apply(2'd0, 1'b0, 1'b0, 1'b1);
        expect_run(1'b0, 3, "R1");

        // R4 / R3: fast regulating
        apply(2'd1, 1'b0, 1'b0, 1'b0);
        expect_run(1'b0, 4, "R4");
        apply(2'd1, 1'b1, 1'b0, 1'b0);
        expect_run(1'b1, 3, "R3");
        apply(2'd1, 1'b0, 1'b0, 1'b0);
        expect_run(1'b1, 5, "R3");
        apply(2'd1, 1'b0, 1'b1, 1'b0);
        expect_run(1'b0, 3, "R3");
        apply(2'd1, 1'b0, 1'b0, 1'b0);
        expect_run(1'b0, 4, "R3");
        apply(2'd1, 1'b1, 1'b1, 1'b0);
        expect_run(1'b0, 3, "R3");
        apply(2'd1, 1'b1, 1'b0, 1'b0);
        expect_run(1'b1, 2, "R3");
        apply(2'd0, 1'b0, 1'b0, 1'b0);
        expect_run(1'b0, 3, "R1");
        // R4: memory cleared by the off phase
        apply(2'd1, 1'b0, 1'b0, 1'b0);
        expect_run(1'b0, 4, "R4");
        apply(2'd0, 1'b0, 1'b0, 1'b0);
        expect_run(1'b0, 2, "R1");

        // R7: reduced -> trickle mid off window -> reduced mid on window
        per = PW'(12);
        apply(2'd2, 1'b0, 1'b0, 1'b1);
        expect_run(1'b1, ONC, "R7"); expect_run(1'b0, 10, "R7");
        apply(2'd3, 1'b0, 1'b0, 1'b1);
        expect_run(1'b1, ONC, "R7"); expect_run(1'b0, (12 - ON) * K, "R7");
        expect_run(1'b1, 3, "R7");
        apply(2'd2, 1'b0, 1'b0, 1'b1);
        expect_run(1'b1, ONC, "R7"); expect_run(1'b0, 5, "R7");
        apply(2'd0, 1'b0, 1'b0, 1'b1);
        expect_run(1'b0, 3, "R1");

        // R8: reduced with hysteresis inside the window
        apply(2'd2, 1'b1, 1'b0, 1'b0);
        expect_run(1'b1, ONC, "R8"); expect_run(1'b0, OFFC, "R8");
        expect_run(1'b1, 2, "R8");
        apply(2'd2, 1'b0, 1'b1, 1'b0);
        expect_run(1'b0, ONC - 2, "R8");
        apply(2'd2, 1'b0, 1'b0, 1'b0);
        expect_run(1'b0, OFFC + ONC + OFFC, "R8");
        apply(2'd2, 1'b1, 1'b0, 1'b0);
        expect_run(1'b1, ONC, "R8"); expect_run(1'b0, 3, "R8");
        apply(2'd0, 1'b0, 1'b0, 1'b0);
        expect_run(1'b0, 3, "R1");

        while (sb_q.size() > 0) @(negedge clk);
        @(negedge clk);
        #1;
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule